// File: doc/BRIEF.md
# Serial Character Receiver with Address Match

This block is one receive channel of an asynchronous serial port. A baud-rate enable pulses sixteen times per bit period. Each pulse is called a tick. The block watches the synchronised line and treats a falling edge as a possible start bit. It confirms the start bit half a bit later. It then takes one sample in the middle of each data bit, the optional parity bit and each stop bit. A received character is placed in a holding register. Status flags go with the character: full, parity, framing error, overrun and line break.

A host reads the held character. It pulses `rd_strobe` on the same cycle to release the holding register. Static configuration inputs set:
- the word length, from 5 to 8 bits;
- parity checking and its mode;
- one or two stop bits;
- what the parity status output shows.

The parity status output can show either a parity error or the raw received parity bit. The raw-bit setting lets the parity position act as an address/data marker on a multidrop line.

Writing a compare value puts the receiver into address-hunt mode. In this mode incoming characters are thrown away until one equals the compare value. That matching character is also consumed. The next character is then delivered normally and sets the full flag.

Top module: `uart_rx_cmp`

## Requirements
- R1: A start bit is accepted only if the line is still low on the 8th tick after the tick that first saw it low. A shorter low pulse leaves every output unchanged, and the receiver goes back to waiting for an edge.
- R2: Data bits are sampled every 16 ticks and assembled least-significant bit first. A received character appears on `rx_data` with `rx_full` = 1.
- R3: `cfg_bits` sets the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `rx_data` above the word length read as 0.
- R4: With `cfg_par_en` = 1 and `cfg_par_show` = 0, `rx_par` goes high when the parity bit does not match `cfg_par_mode`. The modes are: 00 odd (data plus parity has an odd number of ones), 01 even, 10 parity bit must be 1, 11 parity bit must be 0.
- R5: With `cfg_par_show` = 1, `rx_par` shows the parity bit as it was received, whatever the mode.
- R6: A low stop bit sets `rx_frame_err` but still delivers the character. With `cfg_stop2` = 1, a low level in either stop bit counts as a framing error. Reception carries on, and the next good character clears the flag.
- R7: If a character completes while `rx_full` = 1 and no read happens on that cycle, `rx_overrun` is set. The new character is dropped and `rx_data` keeps the old one.
- R8: A break is an all-zero frame with a low first stop bit. It sets `rx_break` and `rx_frame_err` and does not set `rx_full`. No new start is accepted until a tick sees the line high. Normal reception then resumes.
- R9: A `cmp_wr` pulse stores `cmp_data` and starts address hunting. In hunt mode non-matching characters are dropped and `rx_full` stays 0. A character equal to the compare value is consumed and ends hunting, and the next character is delivered.
- R10: A `rd_strobe` pulse clears `rx_full`, the parity error, `rx_frame_err`, `rx_break` and `rx_overrun`. The stored raw parity bit is kept.
- R11: After reset, `rx_data` is 0 and every flag output is 0.
- R12: The flags and `rx_full` change only after the middle of the last stop bit. With two stop bits, nothing is reported at the end of the first stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_bits | input | 2 | Word length select (5 + value) |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_mode | input | 2 | Parity rule: odd, even, one, zero |
| cfg_stop2 | input | 1 | Two stop bits expected |
| cfg_par_show | input | 1 | 1: `rx_par` shows the raw parity bit; 0: `rx_par` shows a parity error |
| cmp_wr | input | 1 | Load compare value and start hunting |
| cmp_data | input | 8 | Compare value |
| rd_strobe | input | 1 | Host has read the character |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Character waiting |
| rx_par | output | 1 | Parity error or raw parity bit |
| rx_frame_err | output | 1 | Stop bit was low |
| rx_overrun | output | 1 | A character was lost |
| rx_break | output | 1 | Break seen on the line |

## Verification
The hardest case to reach is the recovery after a break. The line has to stay low across the stop sample and then keep the receiver in its wait-for-high state for several more bit times. Any falling edge accepted during that time would be a wrongly accepted start bit. The bench holds the line low for three bit periods after an all-zero frame, releases it, and then sends a normal character that must arrive intact. The stop-sample timing is checked by sampling `rx_full` partway into the final stop bit and again at its end. With two stop bits it is also checked at the end of the first stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    parameter int RX_DW = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ONE   = 2'b10,
        PAR_ZERO  = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic             par_bit;
        logic             stop_ok;
        logic             is_break;
    } frame_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
    import uart_rx_pkg::*;
(
    input  logic [RX_DW-1:0] data,
    input  logic             par_bit,
    input  logic [1:0]       mode,
    output logic             ok
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^data;
        unique case (par_mode_e'(mode))
            PAR_ODD:  ok = (ones_odd ^ par_bit) == 1'b1;
            PAR_EVEN: ok = (ones_odd ^ par_bit) == 1'b0;
            PAR_ONE:  ok = par_bit;
            PAR_ZERO: ok = !par_bit;
            default:  ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     rxd_s,
    input  logic [$clog2(RX_DW):0]   nbits,
    input  logic                     par_en,
    input  logic                     stop2,
    output frame_t                   frame_o,
    output logic                     done_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(RX_DW);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [RX_DW-1:0] shreg;
        logic             par_bit;
        logic             any_one;
        logic             stop_ok;
        logic             stop_idx;
        logic             done;
        logic             brk;
    } fsm_t;

    fsm_t s_d, s_q;
    logic last_bit;
    logic at_mid;

    always_comb begin
        last_bit = ({1'b0, s_q.idx} == (nbits - (IDX_W+1)'(1)));
        at_mid   = tick && (s_q.cnt == FULL_M1);
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.brk  = 1'b0;
        if (tick && !at_mid) s_d.cnt = s_q.cnt + CNT_W'(1);
        if (at_mid)          s_d.cnt = '0;

        unique case (s_q.st)
            RX_IDLE: begin
                s_d.cnt = '0;
                if (tick && !rxd_s) s_d.st = RX_START;
            end
            RX_START: begin
                if (tick && s_q.cnt == HALF_M1) begin
                    s_d.cnt = '0;
                    if (!rxd_s) begin
                        s_d.st       = RX_DATA;
                        s_d.idx      = '0;
                        s_d.shreg    = '0;
                        s_d.any_one  = 1'b0;
                        s_d.par_bit  = 1'b0;
                        s_d.stop_ok  = 1'b1;
                        s_d.stop_idx = 1'b0;
                    end else begin
                        s_d.st = RX_IDLE;
                    end
                end
            end
            RX_DATA: begin
                if (at_mid) begin
                    s_d.shreg[s_q.idx] = rxd_s;
                    if (rxd_s) s_d.any_one = 1'b1;
                    if (last_bit) s_d.st  = par_en ? RX_PAR : RX_STOP;
                    else          s_d.idx = s_q.idx + IDX_W'(1);
                end
            end
            RX_PAR: begin
                if (at_mid) begin
                    s_d.par_bit = rxd_s;
                    if (rxd_s) s_d.any_one = 1'b1;
                    s_d.st = RX_STOP;
                end
            end
            RX_STOP: begin
                if (at_mid) begin
                    if (!s_q.stop_idx) begin
                        if (!rxd_s && !s_q.any_one) begin
                            s_d.done    = 1'b1;
                            s_d.brk     = 1'b1;
                            s_d.stop_ok = 1'b0;
                            s_d.st      = RX_HOLD;
                        end else begin
                            s_d.stop_ok = rxd_s;
                            if (stop2) begin
                                s_d.stop_idx = 1'b1;
                            end else begin
                                s_d.done = 1'b1;
                                s_d.st   = RX_IDLE;
                            end
                        end
                    end else begin
                        s_d.stop_ok = s_q.stop_ok & rxd_s;
                        s_d.done    = 1'b1;
                        s_d.st      = RX_IDLE;
                    end
                end
            end
            RX_HOLD: begin
                s_d.cnt = '0;
                if (tick && rxd_s) s_d.st = RX_IDLE;
            end
            default: s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= RX_IDLE;
            s_q.stop_ok  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_o.data     = s_q.shreg;
    assign frame_o.par_bit  = s_q.par_bit;
    assign frame_o.stop_ok  = s_q.stop_ok;
    assign frame_o.is_break = s_q.brk;
    assign done_o           = s_q.done;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  frame_t           frame,
    input  logic             par_ok,
    input  logic             par_en,
    input  logic             rd,
    input  logic             cmp_wr,
    input  logic [RX_DW-1:0] cmp_val,
    output logic [RX_DW-1:0] data_o,
    output logic             full_o,
    output logic             par_err_o,
    output logic             par_bit_o,
    output logic             frame_err_o,
    output logic             overrun_o,
    output logic             brk_o,
    output logic             hunt_o
);
    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic [RX_DW-1:0] cmp;
        logic             full;
        logic             par_err;
        logic             par_bit;
        logic             frame_err;
        logic             overrun;
        logic             brk;
        logic             hunt;
    } stat_t;

    stat_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd) begin
            r_d.full      = 1'b0;
            r_d.par_err   = 1'b0;
            r_d.frame_err = 1'b0;
            r_d.brk       = 1'b0;
            r_d.overrun   = 1'b0;
        end
        if (cmp_wr) begin
            r_d.cmp  = cmp_val;
            r_d.hunt = 1'b1;
        end
        if (done) begin
            if (frame.is_break) begin
                r_d.brk       = 1'b1;
                r_d.frame_err = 1'b1;
            end else if (r_q.hunt) begin
                if (frame.data == r_q.cmp) r_d.hunt = 1'b0;
            end else if (r_q.full && !rd) begin
                r_d.overrun = 1'b1;
            end else begin
                r_d.data      = frame.data;
                r_d.full      = 1'b1;
                r_d.par_err   = par_en & !par_ok;
                r_d.par_bit   = par_en & frame.par_bit;
                r_d.frame_err = !frame.stop_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_o      = r_q.data;
    assign full_o      = r_q.full;
    assign par_err_o   = r_q.par_err;
    assign par_bit_o   = r_q.par_bit;
    assign frame_err_o = r_q.frame_err;
    assign overrun_o   = r_q.overrun;
    assign brk_o       = r_q.brk;
    assign hunt_o      = r_q.hunt;
endmodule

// File: rtl/uart_rx_cmp.sv
module uart_rx_cmp
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rxd,
    input  logic [1:0]       cfg_bits,
    input  logic             cfg_par_en,
    input  logic [1:0]       cfg_par_mode,
    input  logic             cfg_stop2,
    input  logic             cfg_par_show,
    input  logic             cmp_wr,
    input  logic [7:0]       cmp_data,
    input  logic             rd_strobe,
    output logic [7:0]       rx_data,
    output logic             rx_full,
    output logic             rx_par,
    output logic             rx_frame_err,
    output logic             rx_overrun,
    output logic             rx_break
);
    localparam int NB_W = $clog2(RX_DW) + 1;

    logic            rxd_s;
    logic [NB_W-1:0] nbits;
    frame_t          fr;
    logic            fr_done;
    logic            par_ok_w;
    logic            par_err_w;
    logic            par_bit_w;
    logic            hunt_w;

    assign nbits = NB_W'(RX_DW - 3) + NB_W'(cfg_bits);

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_s(rxd_s),
        .nbits(nbits), .par_en(cfg_par_en), .stop2(cfg_stop2),
        .frame_o(fr), .done_o(fr_done)
    );

    uart_rx_parity u_par (
        .data(fr.data), .par_bit(fr.par_bit), .mode(cfg_par_mode), .ok(par_ok_w)
    );

    uart_rx_status u_stat (
        .clk(clk), .rst_n(rst_n), .done(fr_done), .frame(fr),
        .par_ok(par_ok_w), .par_en(cfg_par_en), .rd(rd_strobe),
        .cmp_wr(cmp_wr), .cmp_val(cmp_data),
        .data_o(rx_data), .full_o(rx_full), .par_err_o(par_err_w),
        .par_bit_o(par_bit_w), .frame_err_o(rx_frame_err),
        .overrun_o(rx_overrun), .brk_o(rx_break), .hunt_o(hunt_w)
    );

    assign rx_par = cfg_par_show ? par_bit_w : par_err_w;
endmodule

// File: rtl/uart_rx_cmp_chk.sv
module uart_rx_cmp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd,
    input logic [1:0] cfg_bits,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       rx_frame_err,
    input logic       rx_break,
    input logic       rx_overrun,
    input logic       done,
    input logic       is_brk,
    input logic       hunt
);
    // R3: upper bits beyond the word length are zero when a character lands
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> ((rx_data >> (5 + cfg_bits)) == 8'd0));

    // R7: a held character is never replaced before it is read
    assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd) |=> $stable(rx_data));

    // R8: a break leaves the holding register empty and flags break
    assert_break_no_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_brk && !rx_full) |=> (!rx_full && rx_break));

    // R9: while hunting an empty holder stays empty
    assert_hunt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt && !rx_full) |=> !rx_full);

    // R10: a read with no character completing clears the flags
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!rx_full && !rx_frame_err && !rx_break && !rx_overrun));
endmodule

bind uart_rx_cmp uart_rx_cmp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd(rd_strobe), .cfg_bits(cfg_bits),
    .rx_data(rx_data), .rx_full(rx_full), .rx_frame_err(rx_frame_err),
    .rx_break(rx_break), .rx_overrun(rx_overrun), .done(fr_done),
    .is_brk(fr.is_break), .hunt(hunt_w)
);

// File: tb/sim_uart_rx_cmp.sv
module sim_uart_rx_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_bits = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_par_show = 1'b0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_par, rx_frame_err, rx_overrun, rx_break;

    int checks = 0;
    int errors = 0;
    logic [1:0] tcnt = 2'd0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tcnt   <= tcnt + 2'd1;
        tick16 <= (tcnt == 2'd3);
    end

    uart_rx_cmp u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
        .cfg_stop2(cfg_stop2), .cfg_par_show(cfg_par_show),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .rx_par(rx_par),
        .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .rx_break(rx_break)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one bit period = 16 ticks = 64 clocks
    task automatic send_bit(input logic v);
        rxd = v;
        repeat (64) @(negedge clk);
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int nb, input logic [1:0] m);
        logic x;
        x = ^(d & 8'((1 << nb) - 1));
        case (m)
            2'b00:   return ~x;
            2'b01:   return x;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_body(input logic [7:0] d, input int nb, input logic pen, input logic pbit);
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (pen) send_bit(pbit);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input logic pen, input logic pbit,
                              input logic s1, input logic two, input logic s2);
        send_body(d, nb, pen, pbit);
        send_bit(s1);
        if (two) send_bit(s2);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11", "rx_data", rx_data, 0);
        chk("R11", "flags", {rx_full, rx_par, rx_frame_err, rx_overrun, rx_break}, 0);
    endtask

    task automatic t_basic();
        cfg_bits = 2'b11;
        send_body(8'hA5, 8, 1'b0, 1'b0);
        chk("R12", "full before stop", rx_full, 0);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
        chk("R12", "full early in stop", rx_full, 0);
        repeat (40) @(negedge clk);
        chk("R2", "full after stop", rx_full, 1);
        chk("R2", "data", rx_data, 8'hA5);
        chk("R2", "no errors", {rx_frame_err, rx_overrun, rx_break, rx_par}, 0);
        send_bit(1'b1);
        do_read();
        chk("R10", "full cleared", rx_full, 0);
        // two stop bits: nothing reported at end of the first
        cfg_stop2 = 1'b1;
        send_body(8'h3E, 8, 1'b0, 1'b0);
        send_bit(1'b1);
        chk("R12", "full after first of two stops", rx_full, 0);
        send_bit(1'b1);
        chk("R12", "full after second stop", rx_full, 1);
        chk("R2", "data 2stop", rx_data, 8'h3E);
        send_bit(1'b1);
        do_read();
        cfg_stop2 = 1'b0;
    endtask

    task automatic t_lengths();
        for (int nb = 5; nb < 8; nb++) begin
            cfg_bits = 2'(nb - 5);
            send_frame(8'hFF, nb, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            chk("R3", "short word data", rx_data, 32'((1 << nb) - 1));
            chk("R3", "short word full", rx_full, 1);
            do_read();
        end
        cfg_bits = 2'b11;
    endtask

    task automatic t_parity();
        logic p;
        cfg_par_en = 1'b1;
        cfg_par_show = 1'b0;
        for (int m = 0; m < 4; m++) begin
            cfg_par_mode = 2'(m);
            p = exp_par(8'h35, 8, 2'(m));
            send_frame(8'h35, 8, 1'b1, p, 1'b1, 1'b0, 1'b1);
            chk("R4", "good parity", rx_par, 0);
            chk("R4", "data with parity", rx_data, 8'h35);
            do_read();
            send_frame(8'h35, 8, 1'b1, ~p, 1'b1, 1'b0, 1'b1);
            chk("R4", "bad parity", rx_par, 1);
            do_read();
            chk("R10", "parity error cleared", rx_par, 0);
        end
        // raw parity view
        cfg_par_show = 1'b1;
        cfg_par_mode = 2'b01;
        send_frame(8'h81, 8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R5", "raw parity 1", rx_par, 1);
        do_read();
        chk("R10", "raw parity kept after read", rx_par, 1);
        send_frame(8'h81, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R5", "raw parity 0", rx_par, 0);
        do_read();
        cfg_par_show = 1'b0;
        cfg_par_en = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6", "frame err set", rx_frame_err, 1);
        chk("R6", "frame err data delivered", {rx_full, rx_data}, {1'b1, 8'h3C});
        do_read();
        send_frame(8'h42, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R6", "good char clears frame err", rx_frame_err, 0);
        chk("R6", "reception continues", rx_data, 8'h42);
        do_read();
        cfg_stop2 = 1'b1;
        send_frame(8'h19, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6", "second stop low", rx_frame_err, 1);
        do_read();
        cfg_stop2 = 1'b0;
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R7", "overrun set", rx_overrun, 1);
        chk("R7", "old data kept", rx_data, 8'h11);
        do_read();
        chk("R10", "overrun and full cleared", {rx_overrun, rx_full}, 0);
    endtask

    task automatic t_break();
        send_body(8'h00, 8, 1'b0, 1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        chk("R8", "break flag while low", rx_break, 1);
        chk("R8", "no full on break", rx_full, 0);
        chk("R8", "frame err on break", rx_frame_err, 1);
        send_bit(1'b1);
        send_bit(1'b1);
        chk("R8", "still empty after release", rx_full, 0);
        do_read();
        chk("R10", "break cleared", rx_break, 0);
        send_frame(8'h5C, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R8", "reception resumes", {rx_full, rx_data}, {1'b1, 8'h5C});
        do_read();
    endtask

    task automatic t_false_start();
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        chk("R1", "glitch ignored", {rx_full, rx_frame_err, rx_break}, 0);
        send_frame(8'h6B, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R1", "real start after glitch", {rx_full, rx_data}, {1'b1, 8'h6B});
        do_read();
    endtask

    task automatic t_compare();
        @(negedge clk) begin cmp_data = 8'h5A; cmp_wr = 1'b1; end
        @(negedge clk) cmp_wr = 1'b0;
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9", "mismatch dropped", rx_full, 0);
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9", "match consumed", rx_full, 0);
        send_frame(8'h33, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9", "next char delivered", {rx_full, rx_data}, {1'b1, 8'h33});
        do_read();
        send_frame(8'h44, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9", "normal after match", {rx_full, rx_data}, {1'b1, 8'h44});
        do_read();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        send_bit(1'b1);
        t_basic();
        t_lengths();
        t_parity();
        t_framing();
        t_overrun();
        t_break();
        t_false_start();
        t_compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule